// File: doc/BRIEF.md
# Sample Period Timer with LED Strobe

This block sets the sampling instants of a quadrature decoder and drives the illumination LED that an optical encoder needs. A free-running microsecond enable (`tick_1us_i`) is the time base. A 4-bit period code picks a sample period of 128 µs times a power of two. Codes 0 to 10 cover 128 µs to 131072 µs, and codes above 10 are treated as 10. Each sample instant appears as a one-cycle strobe. Decoding, input filtering and pin routing are left to the blocks around it.

The LED is switched to its active level a programmable number of microsecond ticks before each strobe (lead time, 9 bits, reset value 16). It returns to its inactive level in the strobe cycle itself. If the lead time is at least as long as the period, or if the neighbouring input filters are enabled, the LED stays active for the whole run. A polarity input selects whether active means high or low.

A start command begins sampling, and the first strobe comes one full period later. A stop command halts the timer and answers with a one-cycle stopped pulse. The configuration inputs follow the pins while the timer is stopped. They are frozen from the start command until the timer stops, so a change made during operation is ignored.

Top module: `smpl_strobe_timer`

## Requirements
- R1: After reset, `sample_stb_o`, `stopped_o` and `running_o` are 0 and `led_o` is 1, because the reset polarity is active-low and the LED is inactive.
- R2: With `tick_1us_i` high every cycle, the first `sample_stb_o` pulse is seen exactly 128 << code cycles after the clock edge that accepts `start_i`. Each pulse lasts one cycle, and pulses repeat every 128 << code ticks.
- R3: The period counter advances only on cycles where `tick_1us_i` is 1. While the tick is held at 0, no strobe is produced and the count does not move.
- R4: When the lead time L is nonzero and smaller than the period P, `led_o` is at its active level for exactly the L ticks before each strobe. It is inactive in the strobe cycle.
- R5: When the lead time is greater than or equal to the period, `led_o` is active on every cycle of the run, including the strobe cycle.
- R6: The active LED level equals `led_active_high_i` (1 means active high, 0 means active low). While the timer is stopped, `led_o` shows the inactive level, which is the inverse of the polarity input.
- R7: When `filter_en_i` is 1 at start, `led_o` is active on every cycle of the run, whatever the lead time is.
- R8: `stop_i` drops `running_o` on the next cycle and pulses `stopped_o` for one cycle. No strobe follows it. If `start_i` and `stop_i` arrive together, stop wins.
- R9: While running, changes to the period code, lead time, polarity and filter inputs have no effect, and a second `start_i` is ignored. The strobe position and the LED window stay as they were set at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1us_i | input | 1 | One-cycle enable once per microsecond |
| start_i | input | 1 | Start command pulse |
| stop_i | input | 1 | Stop command pulse |
| period_code_i | input | 4 | Sample period code; period = 128 << code ticks, clamped to code 10 |
| lead_us_i | input | 9 | LED lead time before each strobe, in ticks |
| led_active_high_i | input | 1 | LED polarity: 1 active high, 0 active low |
| filter_en_i | input | 1 | Input filters enabled: LED held active while running |
| sample_stb_o | output | 1 | One-cycle sample strobe |
| led_o | output | 1 | LED drive at the selected polarity |
| stopped_o | output | 1 | One-cycle pulse confirming a stop |
| running_o | output | 1 | Timer is running |

## Verification
The properties assume that the commands and configuration are synchronous to `clk_i`. They also assume that the tick is a single-cycle enable and not a second clock. The idle-polarity property also relies on the LED level being computed from the polarity present at the previous edge. The stimulus changes every input one nanosecond after a rising edge and holds it for whole cycles. Every run uses periods of at least 128 ticks, so two strobes can never fall in adjacent cycles. Configuration changes during a run are made on purpose, to show that they are ignored. The stop-wins case is driven by raising both commands in the same cycle.

// File: rtl/smpl_tmr_pkg.sv
`timescale 1ns/1ps
package smpl_tmr_pkg;

    localparam int CODE_W     = 4;
    localparam int LEAD_W     = 9;
    localparam int BASE_SHIFT = 7;
    localparam int MAX_CODE   = 10;
    localparam int CNT_W      = BASE_SHIFT + MAX_CODE + 1;
    localparam int LEAD_RST   = 16;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LEAD_W-1:0] lead;
        logic              pol;
        logic              filt;
    } tmr_cfg_t;

    localparam tmr_cfg_t CFG_RST = '{
        code: '0,
        lead: LEAD_W'(LEAD_RST),
        pol:  1'b0,
        filt: 1'b0
    };

    // Period in ticks for a code, clamped to the largest supported code.
    function automatic logic [CNT_W-1:0] period_of(input logic [CODE_W-1:0] c);
        logic [CODE_W-1:0] k;
        logic [CNT_W-1:0]  one;
        k   = (int'(c) > MAX_CODE) ? CODE_W'(MAX_CODE) : c;
        one = CNT_W'(1);
        return one << (BASE_SHIFT + int'(k));
    endfunction

endpackage

// File: rtl/smpl_run_ctrl.sv
`timescale 1ns/1ps
module smpl_run_ctrl
    import smpl_tmr_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     start_i,
    input  logic     stop_i,
    input  tmr_cfg_t cfg_i,
    output logic     run_d_o,
    output logic     run_q_o,
    output tmr_cfg_t cfg_d_o,
    output tmr_cfg_t cfg_q_o,
    output logic     stopped_o
);

    typedef struct packed {
        logic     run;
        logic     stopped;
        tmr_cfg_t cfg;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.stopped = stop_i;
        // configuration follows the pins only while idle
        if (!s_q.run) begin
            s_d.cfg = cfg_i;
        end
        if (stop_i) begin
            s_d.run = 1'b0;
        end else if (start_i) begin
            s_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{run: 1'b0, stopped: 1'b0, cfg: CFG_RST};
        end else begin
            s_q <= s_d;
        end
    end

    assign run_d_o   = s_d.run;
    assign run_q_o   = s_q.run;
    assign cfg_d_o   = s_d.cfg;
    assign cfg_q_o   = s_q.cfg;
    assign stopped_o = s_q.stopped;

endmodule

// File: rtl/smpl_period_dec.sv
`timescale 1ns/1ps
module smpl_period_dec
    import smpl_tmr_pkg::*;
#(
    parameter int N_SEL = 2
) (
    input  logic [N_SEL-1:0][CODE_W-1:0] code_i,
    output logic [N_SEL-1:0][CNT_W-1:0]  period_o
);

    for (genvar g = 0; g < N_SEL; g++) begin : g_dec
        always_comb begin
            period_o[g] = period_of(code_i[g]);
        end
    end

endmodule

// File: rtl/smpl_period_cnt.sv
`timescale 1ns/1ps
module smpl_period_cnt
    import smpl_tmr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             run_q_i,
    input  logic             run_d_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             stb_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       at_end;

    assign at_end = (s_q.cnt == period_i - CNT_W'(1));

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        if (run_q_i && tick_i) begin
            if (at_end) begin
                s_d.cnt = '0;
                s_d.stb = run_d_i;
            end else begin
                s_d.cnt = s_q.cnt + CNT_W'(1);
            end
        end
        if (!run_d_i) begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_d_o = s_d.cnt;
    assign stb_o   = s_q.stb;

endmodule

// File: rtl/smpl_led_drv.sv
`timescale 1ns/1ps
module smpl_led_drv
    import smpl_tmr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_d_i,
    input  logic [CNT_W-1:0] cnt_d_i,
    input  logic [CNT_W-1:0] period_d_i,
    input  tmr_cfg_t         cfg_d_i,
    output logic             led_o
);

    typedef struct packed {
        logic led;
    } led_state_t;

    led_state_t       s_d, s_q;
    logic [CNT_W-1:0] lead_ext;
    logic             whole_run;
    logic             in_window;
    logic             active;

    assign lead_ext  = CNT_W'(cfg_d_i.lead);
    assign whole_run = cfg_d_i.filt || (lead_ext >= period_d_i);
    assign in_window = cnt_d_i >= (period_d_i - lead_ext);
    assign active    = run_d_i && (whole_run || in_window);

    always_comb begin
        s_d.led = active ? cfg_d_i.pol : !cfg_d_i.pol;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.led <= !CFG_RST.pol;
        end else begin
            s_q <= s_d;
        end
    end

    assign led_o = s_q.led;

endmodule

// File: rtl/smpl_strobe_timer.sv
`timescale 1ns/1ps
module smpl_strobe_timer
    import smpl_tmr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_1us_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [CODE_W-1:0] period_code_i,
    input  logic [LEAD_W-1:0] lead_us_i,
    input  logic              led_active_high_i,
    input  logic              filter_en_i,
    output logic              sample_stb_o,
    output logic              led_o,
    output logic              stopped_o,
    output logic              running_o
);

    tmr_cfg_t                cfg_pins;
    tmr_cfg_t                run_cfg_d, run_cfg_q;
    logic                    run_d, run_q;
    logic [1:0][CODE_W-1:0]  codes;
    logic [1:0][CNT_W-1:0]   periods;
    logic [CNT_W-1:0]        cnt_d;

    assign cfg_pins = '{
        code: period_code_i,
        lead: lead_us_i,
        pol:  led_active_high_i,
        filt: filter_en_i
    };

    smpl_run_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .stop_i    (stop_i),
        .cfg_i     (cfg_pins),
        .run_d_o   (run_d),
        .run_q_o   (run_q),
        .cfg_d_o   (run_cfg_d),
        .cfg_q_o   (run_cfg_q),
        .stopped_o (stopped_o)
    );

    // index 0: period in force now, index 1: period for the next cycle
    assign codes[0] = run_cfg_q.code;
    assign codes[1] = run_cfg_d.code;

    smpl_period_dec #(.N_SEL(2)) u_dec (
        .code_i   (codes),
        .period_o (periods)
    );

    smpl_period_cnt u_cnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .tick_i   (tick_1us_i),
        .run_q_i  (run_q),
        .run_d_i  (run_d),
        .period_i (periods[0]),
        .cnt_d_o  (cnt_d),
        .stb_o    (sample_stb_o)
    );

    smpl_led_drv u_led (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_d_i    (run_d),
        .cnt_d_i    (cnt_d),
        .period_d_i (periods[1]),
        .cfg_d_i    (run_cfg_d),
        .led_o      (led_o)
    );

    assign running_o = run_q;

endmodule

module smpl_strobe_timer_chk
    import smpl_tmr_pkg::*;
(
    input logic     clk_i,
    input logic     rst_ni,
    input logic     tick_1us_i,
    input logic     stop_i,
    input logic     led_active_high_i,
    input logic     sample_stb_o,
    input logic     led_o,
    input logic     stopped_o,
    input logic     running_o,
    input tmr_cfg_t lat_cfg
);

    logic past_ok;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    // R2
    strobe_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |=> !sample_stb_o);

    // R3
    strobe_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_stb_o |-> ($past(tick_1us_i) && $past(running_o)));

    // R8
    stop_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> (!running_o && !sample_stb_o && stopped_o));

    // R8
    stopped_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stopped_o && !$past(stop_i)) |-> 1'b0 == past_ok);

    // R6
    idle_led_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (past_ok && !running_o && !$past(running_o)) |-> (led_o == !$past(led_active_high_i)));

    // R9
    cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(running_o) |-> $stable(lat_cfg));

endmodule

bind smpl_strobe_timer smpl_strobe_timer_chk chk_i (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .tick_1us_i        (tick_1us_i),
    .stop_i            (stop_i),
    .led_active_high_i (led_active_high_i),
    .sample_stb_o      (sample_stb_o),
    .led_o             (led_o),
    .stopped_o         (stopped_o),
    .running_o         (running_o),
    .lat_cfg           (run_cfg_q)
);

// File: tb/smpl_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module smpl_strobe_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic       stop = 1'b0;
    logic [3:0] code = 4'd0;
    logic [8:0] lead = 9'd16;
    logic       pol = 1'b0;
    logic       filt = 1'b0;
    logic       stb, led, stopped, running;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    smpl_strobe_timer dut_i (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .tick_1us_i        (tick),
        .start_i           (start),
        .stop_i            (stop),
        .period_code_i     (code),
        .lead_us_i         (lead),
        .led_active_high_i (pol),
        .filter_en_i       (filt),
        .sample_stb_o      (stb),
        .led_o             (led),
        .stopped_o         (stopped),
        .running_o         (running)
    );

    typedef struct packed {
        logic [3:0]  code;
        logic [8:0]  lead;
        logic        pol;
        logic        filt;
        logic [15:0] led_cnt;
        logic        led_at_stb;
    } vec_t;

    // expected LED-active edges before the strobe, and LED state in the strobe cycle
    localparam vec_t VECS [5] = '{
        '{4'd0, 9'd16,  1'b1, 1'b0, 16'd16,  1'b0},
        '{4'd1, 9'd1,   1'b0, 1'b0, 16'd1,   1'b0},
        '{4'd0, 9'd200, 1'b1, 1'b0, 16'd127, 1'b1},
        '{4'd2, 9'd300, 1'b0, 1'b0, 16'd300, 1'b0},
        '{4'd0, 9'd5,   1'b1, 1'b1, 16'd127, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        start = 1'b1;
        step();
        start = 1'b0;
    endtask

    task automatic do_stop();
        stop = 1'b1;
        step();
        stop = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int first;
        int lcnt;
        int lstb;
        int per;
        int nstb;

        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 strobe", int'(stb), 0);
        check("R1 stopped", int'(stopped), 0);
        check("R1 running", int'(running), 0);
        check("R1 led", int'(led), 1);

        // R6 idle polarity
        pol = 1'b1;
        step(); step();
        check("R6 idle led active-high", int'(led), 0);
        pol = 1'b0;
        step(); step();
        check("R6 idle led active-low", int'(led), 1);

        // table walk: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < 5; v++) begin
            code = VECS[v].code;
            lead = VECS[v].lead;
            pol  = VECS[v].pol;
            filt = VECS[v].filt;
            step(); step();
            do_start();
            per   = 128 << VECS[v].code;
            first = -1;
            lcnt  = 0;
            lstb  = -1;
            for (int k = 1; k <= per; k++) begin
                step();
                if (stb && first < 0) begin
                    first = k;
                    lstb  = int'(led == VECS[v].pol);
                end
                if (k < per && led == VECS[v].pol) lcnt++;
            end
            check("R2 first strobe", first, per);
            check("R4/R5/R7 led window", lcnt, int'(VECS[v].led_cnt));
            check("R4/R5/R7 led at strobe", lstb, int'(VECS[v].led_at_stb));
            do_stop();
            check("R8 running after stop", int'(running), 0);
            check("R8 stopped pulse", int'(stopped), 1);
            check("R6 led inactive when stopped", int'(led), int'(!VECS[v].pol));
            step();
            check("R8 stopped one cycle", int'(stopped), 0);
        end

        // R2 periodicity and R9 frozen config / repeated start
        code = 4'd0; lead = 9'd16; pol = 1'b1; filt = 1'b0;
        step(); step();
        do_start();
        nstb = 0; first = -1; lcnt = 0;
        for (int k = 1; k <= 256; k++) begin
            step();
            if (k == 5) begin
                code = 4'd3; lead = 9'd50; pol = 1'b0; filt = 1'b1;
            end
            if (k == 20) start = 1'b1;
            if (k == 21) start = 1'b0;
            if (stb) begin
                nstb++;
                if (first < 0) first = k;
                if (k == 256) check("R2 second strobe at 256", k, 256);
            end
            if (k < 128 && led == 1'b1) lcnt++;
        end
        check("R9 first strobe unchanged", first, 128);
        check("R2 two strobes in two periods", nstb, 2);
        check("R9 led window unchanged", lcnt, 16);
        do_stop();
        code = 4'd0; lead = 9'd16; pol = 1'b0; filt = 1'b0;
        step(); step();

        // R3 tick gating
        tick = 1'b0;
        do_start();
        nstb = 0;
        for (int k = 0; k < 300; k++) begin
            step();
            if (stb) nstb++;
        end
        check("R3 no strobe without tick", nstb, 0);
        check("R3 led inactive during stall", int'(led), 1);
        tick = 1'b1;
        first = -1;
        for (int k = 1; k <= 130; k++) begin
            step();
            if (stb && first < 0) first = k;
        end
        check("R3 strobe after 128 ticks", first, 128);
        do_stop();
        step();

        // R8 stop mid-run: no later strobe
        do_start();
        repeat (60) step();
        do_stop();
        nstb = 0;
        for (int k = 0; k < 200; k++) begin
            step();
            if (stb) nstb++;
        end
        check("R8 no strobe after stop", nstb, 0);

        // R8 start and stop together: stop wins
        start = 1'b1; stop = 1'b1;
        step();
        start = 1'b0; stop = 1'b0;
        check("R8 stop wins running", int'(running), 0);
        check("R8 stop wins stopped pulse", int'(stopped), 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule